// File: doc/BRIEF.md
# Multichannel audio sample FIFO port

This block is one direction of a serial audio port. It holds audio samples between a CPU-facing register interface and a serialiser. In the playback variant the CPU writes samples and the serialiser takes them one at a time. In the capture variant the serialiser hands samples in and the CPU reads them out. A single parameter selects the direction.

The backing RAM holds `256 << SIZE_SEL` words. The RAM is divided into frames of one sample per channel. The channel count is rounded up to a power of two when the frame capacity is worked out, so three channels get the same number of frames as four. Software sees the fill level as a count of whole frames. Overrun and underrun flags stay set until software clears them. A half-level interrupt request tells software when to refill the FIFO (playback) or when to drain it (capture).

Software finds the RAM size by reading a read-only configuration register. It sets the half-level interrupt enable and flushes the FIFO through the control register. It polls or services the status register and moves samples through one of two data windows: a full 24-bit window and a 16-bit window.

Top module: `audio_sample_fifo`

## Requirements
- R1: The frame capacity is `(256 << SIZE_SEL) >> k`, where `k` is the smallest integer with `2^k >= C` and C is the channel count taken from `cfg_chans` (0 counts as 1, values above MAX_CH count as MAX_CH). The FIFO takes exactly capacity × C samples before it is full. Reading address 4 returns SIZE_SEL in bits [2:0].
- R2: Reading status (address 1) returns the stored frame count in bits [8+AW:8], which is [16:8] by default. A frame is counted only once the sample for its last channel has been written, and it stays counted until its last sample has been taken out.
- R3: Samples come out in the order they went in. The 24-bit data window (address 2) carries a sample in bits [23:0]. On write, bits [31:24] are ignored. On read, bits [31:24] are zero.
- R4: The 16-bit data window (address 3) stores write bits [15:0] as sample bits [23:8], with zero in sample bits [7:0]. On read it returns sample bits [23:8] in bits [15:0], with all upper bits zero.
- R5: Playback: a CPU data write while the FIFO is full is dropped and sets the overrun flag (status bit 4).
- R6: Playback: a serialiser pop (`ser_strobe`) from an empty FIFO sets the underrun flag (status bit 0), and `ser_dout` reads zero during that pop.
- R7: Capture: a serialiser push (`ser_strobe` with `ser_din`) into a full FIFO is dropped and sets the overrun flag (status bit 4).
- R8: Capture: a CPU data read from an empty FIFO returns zero and sets the underrun flag (status bit 0).
- R9: Both flags are sticky. A status write keeps each flag whose bit (4 or 0) is 1 in the write data and clears each flag whose bit is 0. Writing zero therefore clears both.
- R10: Writing control (address 0) with bit 0 set empties the FIFO at that edge, so the next status read shows zero frames. The error flags are left unchanged.
- R11: Control bit 20 enables the interrupt and reads back in the same bit. With the enable set, playback raises `irq` while stored frames are at or below capacity/2, and capture raises it while stored frames are at or above capacity/2. With the enable clear, `irq` is low.
- R12: After reset the FIFO is empty, both flags are clear, the interrupt enable is 0, status reads 0 and `irq` is low.
- R13: Data-window accesses in the wrong direction have no effect. In playback, a CPU data read returns zero and removes nothing. In capture, a CPU data write stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chans | input | $clog2(MAX_CH)+1 | Channel count per frame |
| reg_addr | input | 3 | Register select: 0 control, 1 status, 2 data 24-bit, 3 data 16-bit, 4 configuration |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on a capture data read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the access |
| ser_strobe | input | 1 | Serialiser sample strobe: pop in playback, push in capture |
| ser_din | input | 24 | Sample pushed by the serialiser (capture) |
| ser_dout | output | 24 | Sample offered to the serialiser (playback), zero when empty |
| irq | output | 1 | Half-level interrupt request |

## Verification
The assertions assume that `cfg_chans` changes only in the same cycle as a control write that clears the FIFO. Under that assumption the fill bound and the capacity seen by the overrun checks stay consistent with what is stored. They also assume `reg_wr` and `reg_rd` are never used to change the channel layout of data already held. The stimulus keeps to these assumptions: every channel change, directed or random, goes out together with a clearing control write, and the random phase chooses a new layout only at those points. The random mix shifts its bias between filling and draining, so both the full and the empty boundaries, and the interrupt threshold, are crossed repeatedly.

// File: rtl/asf_pkg.sv
package asf_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_STAT   = 3'd1,
        RA_DATA   = 3'd2,
        RA_DATA16 = 3'd3,
        RA_CFG    = 3'd4
    } reg_addr_e;

    localparam int CTRL_CLR_BIT  = 0;
    localparam int CTRL_HALF_BIT = 20;
    localparam int STAT_UND_BIT  = 0;
    localparam int STAT_OVR_BIT  = 4;
    localparam int STAT_FILL_LSB = 8;
    localparam int SAMPLE_W      = 24;
    localparam int NARROW_W      = 16;
    localparam int BASE_AW       = 8;

endpackage

// File: rtl/asf_capacity.sv
module asf_capacity #(
    parameter int AW     = 8,
    parameter int MAX_CH = 8
) (
    input  logic [$clog2(MAX_CH):0] chans_in,
    output logic [$clog2(MAX_CH):0] chans_eff,
    output logic [AW:0]             cap_frames,
    output logic [AW:0]             cap_words
);
    localparam int CNW   = $clog2(MAX_CH) + 1;
    localparam int CW    = AW + 1;
    localparam int WORDS = 1 << AW;

    int sh;

    always_comb begin
        if (chans_in == '0) begin
            chans_eff = CNW'(1);
        end else if (chans_in > CNW'(MAX_CH)) begin
            chans_eff = CNW'(MAX_CH);
        end else begin
            chans_eff = chans_in;
        end
        // round the channel count up to a power of two
        sh = 0;
        for (int i = 0; i < CNW; i++) begin
            if ((32'd1 << i) < 32'(chans_eff)) begin
                sh = i + 1;
            end
        end
        cap_frames = CW'(WORDS) >> sh;
        cap_words  = cap_frames * CW'(chans_eff);
    end

endmodule

// File: rtl/asf_store.sv
module asf_store #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter bit PLAYBACK = 1'b1,
    parameter int SIZE_SEL = 0,
    parameter int MAX_CH   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(MAX_CH):0] cfg_chans,
    input  logic [2:0]              reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    ser_strobe,
    input  logic [SAMPLE_W-1:0]     ser_din,
    output logic [SAMPLE_W-1:0]     ser_dout,
    output logic                    irq
);
    localparam int AW  = BASE_AW + SIZE_SEL;
    localparam int CW  = AW + 1;
    localparam int CNW = $clog2(MAX_CH) + 1;

    typedef struct packed {
        logic [AW-1:0]  wptr;
        logic [AW-1:0]  rptr;
        logic [CW-1:0]  words;
        logic [CW-1:0]  frames;
        logic [CNW-1:0] wch;
        logic [CNW-1:0] rch;
        logic           ovr;
        logic           und;
        logic           half_en;
    } state_t;

    state_t q, d;

    logic [CNW-1:0]      chans;
    logic [CW-1:0]       cap_frames, cap_words, half_mark;
    logic                data_sel, clr, wr_req, rd_req, full, empty;
    logic                do_wr, do_rd, wr_last, rd_last;
    logic [SAMPLE_W-1:0] wr_sample, rd_sample;
    logic                unused_inputs;

    // signals brought out for the bound checker
    logic [CW-1:0]       fill_words, fill_frames;
    logic                flag_ovr, flag_und, irq_en;

    asf_capacity #(.AW(AW), .MAX_CH(MAX_CH)) u_capacity (
        .chans_in   (cfg_chans),
        .chans_eff  (chans),
        .cap_frames (cap_frames),
        .cap_words  (cap_words)
    );

    asf_store #(.DW(SAMPLE_W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (do_wr),
        .waddr (q.wptr),
        .wdata (wr_sample),
        .raddr (q.rptr),
        .rdata (rd_sample)
    );

    assign unused_inputs = ^{reg_wdata, ser_din, reg_rd};

    always_comb begin
        data_sel = (reg_addr == RA_DATA) || (reg_addr == RA_DATA16);
        clr      = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_CLR_BIT];
        if (PLAYBACK) begin
            wr_req    = reg_wr && data_sel;
            rd_req    = ser_strobe;
            wr_sample = (reg_addr == RA_DATA16)
                      ? {reg_wdata[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}}
                      : reg_wdata[SAMPLE_W-1:0];
        end else begin
            wr_req    = ser_strobe;
            rd_req    = reg_rd && data_sel;
            wr_sample = ser_din;
        end
        full    = q.words >= cap_words;
        empty   = q.words == '0;
        do_wr   = wr_req && !full && !clr;
        do_rd   = rd_req && !empty && !clr;
        wr_last = q.wch == chans - 1'b1;
        rd_last = q.rch == chans - 1'b1;

        d = q;
        if (do_wr) begin
            d.wptr = q.wptr + 1'b1;
            d.wch  = wr_last ? '0 : q.wch + 1'b1;
        end
        if (do_rd) begin
            d.rptr = q.rptr + 1'b1;
            d.rch  = rd_last ? '0 : q.rch + 1'b1;
        end
        d.words  = q.words + CW'(do_wr) - CW'(do_rd);
        d.frames = q.frames + CW'(do_wr && wr_last) - CW'(do_rd && rd_last);

        if (reg_wr && (reg_addr == RA_CTRL)) begin
            d.half_en = reg_wdata[CTRL_HALF_BIT];
        end
        if (reg_wr && (reg_addr == RA_STAT)) begin
            d.ovr = q.ovr & reg_wdata[STAT_OVR_BIT];
            d.und = q.und & reg_wdata[STAT_UND_BIT];
        end
        if (wr_req && full && !clr) begin
            d.ovr = 1'b1;
        end
        if (rd_req && empty && !clr) begin
            d.und = 1'b1;
        end

        if (clr) begin
            d.wptr   = '0;
            d.rptr   = '0;
            d.words  = '0;
            d.frames = '0;
            d.wch    = '0;
            d.rch    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: reg_rdata[CTRL_HALF_BIT] = q.half_en;
            RA_STAT: begin
                reg_rdata[STAT_FILL_LSB +: CW] = q.frames;
                reg_rdata[STAT_OVR_BIT]        = q.ovr;
                reg_rdata[STAT_UND_BIT]        = q.und;
            end
            RA_DATA: begin
                if (!PLAYBACK && !empty) reg_rdata[SAMPLE_W-1:0] = rd_sample;
            end
            RA_DATA16: begin
                if (!PLAYBACK && !empty) reg_rdata[NARROW_W-1:0] = rd_sample[SAMPLE_W-1 -: NARROW_W];
            end
            RA_CFG:  reg_rdata[2:0] = 3'(SIZE_SEL);
            default: ;
        endcase
    end

    always_comb begin
        half_mark = cap_frames >> 1;
        ser_dout  = (PLAYBACK && !empty) ? rd_sample : '0;
        if (PLAYBACK) begin
            irq = q.half_en && (q.frames <= half_mark);
        end else begin
            irq = q.half_en && (q.frames >= half_mark);
        end
    end

    assign fill_words  = q.words;
    assign fill_frames = q.frames;
    assign flag_ovr    = q.ovr;
    assign flag_und    = q.und;
    assign irq_en      = q.half_en;

endmodule

// File: rtl/asf_chk.sv
module asf_chk
    import asf_pkg::*;
#(
    parameter bit PLAYBACK = 1'b1,
    parameter int CW       = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          wd_b0,
    input logic          wd_b4,
    input logic          ser_strobe,
    input logic [23:0]   ser_dout,
    input logic          irq,
    input logic          irq_en,
    input logic [CW-1:0] words,
    input logic [CW-1:0] frames,
    input logic [CW-1:0] cap_words,
    input logic          flag_ovr,
    input logic          flag_und
);
    logic clr_wr, stat_wr, data_addr;
    assign clr_wr    = reg_wr && (reg_addr == RA_CTRL) && wd_b0;
    assign stat_wr   = reg_wr && (reg_addr == RA_STAT);
    assign data_addr = (reg_addr == RA_DATA) || (reg_addr == RA_DATA16);

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (words == '0 && frames == '0));

    // R10
    clear_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !stat_wr) |=> (flag_ovr == $past(flag_ovr) && flag_und == $past(flag_und)));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr && !stat_wr) |=> flag_ovr);

    // R9
    und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_und && !stat_wr) |=> flag_und);

    // R9
    zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wd_b4 && !wd_b0 && !ser_strobe && !reg_rd) |=> (!flag_ovr && !flag_und));

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= words);

    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    if (PLAYBACK) begin : g_play
        // R5
        play_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && data_addr && words >= cap_words) |=> flag_ovr);
        // R6
        play_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ser_strobe && words == '0) |-> ser_dout == '0);
        // R6
        play_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ser_strobe && words == '0 && !clr_wr) |=> flag_und);
        // R11
        play_irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_en && frames == '0) |-> irq);
    end else begin : g_cap
        // R7
        cap_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ser_strobe && words >= cap_words && !clr_wr) |=> flag_ovr);
        // R8
        cap_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && data_addr && words == '0) |=> flag_und);
    end

endmodule

bind audio_sample_fifo asf_chk #(.PLAYBACK(PLAYBACK), .CW(CW)) u_asf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .wd_b0      (reg_wdata[0]),
    .wd_b4      (reg_wdata[4]),
    .ser_strobe (ser_strobe),
    .ser_dout   (ser_dout),
    .irq        (irq),
    .irq_en     (irq_en),
    .words      (fill_words),
    .frames     (fill_frames),
    .cap_words  (cap_words),
    .flag_ovr   (flag_ovr),
    .flag_und   (flag_und)
);

// File: tb/audio_sample_fifo_bench.sv
`timescale 1ns/1ps
module audio_sample_fifo_bench;
    import asf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  chans  [2];
    logic [2:0]  addr   [2];
    logic        wr     [2];
    logic        rd     [2];
    logic [31:0] wdata  [2];
    logic [31:0] rdata  [2];
    logic        strobe [2];
    logic [23:0] din    [2];
    logic [23:0] dout   [2];
    logic        irq    [2];

    always #2 clk = ~clk;

    audio_sample_fifo #(.PLAYBACK(1'b1)) u_audio_sample_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_chans(chans[0]), .reg_addr(addr[0]),
        .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_wdata(wdata[0]), .reg_rdata(rdata[0]),
        .ser_strobe(strobe[0]), .ser_din(din[0]), .ser_dout(dout[0]), .irq(irq[0]));

    audio_sample_fifo #(.PLAYBACK(1'b0)) u_audio_sample_fifo_cap (
        .clk(clk), .rst_n(rst_n), .cfg_chans(chans[1]), .reg_addr(addr[1]),
        .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_wdata(wdata[1]), .reg_rdata(rdata[1]),
        .ser_strobe(strobe[1]), .ser_din(din[1]), .ser_dout(dout[1]), .irq(irq[1]));

    // reference model, index 0 playback, 1 capture
    logic [23:0] mm [2][256];
    int mw[2], mr[2], mcnt[2], mfr[2], mwc[2], mrc[2], mch[2];
    bit movr[2], mund[2], men[2];
    int checks = 0;
    int fails  = 0;

    function automatic int eff_ch(int ch);
        if (ch < 1) return 1;
        if (ch > 8) return 8;
        return ch;
    endfunction

    function automatic int cap_of(int ch);
        int c;
        int s;
        c = eff_ch(ch);
        s = 0;
        while ((1 << s) < c) s++;
        return 256 >> s;
    endfunction

    function automatic void m_clear(int s);
        mw[s] = 0; mr[s] = 0; mcnt[s] = 0; mfr[s] = 0; mwc[s] = 0; mrc[s] = 0;
    endfunction

    function automatic void m_push(int s, logic [23:0] v);
        int ch;
        ch = eff_ch(mch[s]);
        if (mcnt[s] >= cap_of(mch[s]) * ch) begin
            movr[s] = 1'b1;
        end else begin
            mm[s][mw[s]] = v;
            mw[s] = (mw[s] + 1) % 256;
            mcnt[s]++;
            mwc[s]++;
            if (mwc[s] == ch) begin mwc[s] = 0; mfr[s]++; end
        end
    endfunction

    function automatic logic [23:0] m_pop(int s);
        int ch;
        logic [23:0] v;
        ch = eff_ch(mch[s]);
        if (mcnt[s] == 0) begin
            mund[s] = 1'b1;
            return 24'h0;
        end
        v = mm[s][mr[s]];
        mr[s] = (mr[s] + 1) % 256;
        mcnt[s]--;
        mrc[s]++;
        if (mrc[s] == ch) begin mrc[s] = 0; mfr[s]--; end
        return v;
    endfunction

    function automatic logic [31:0] m_status(int s);
        return (32'(mfr[s]) << 8) | (32'(movr[s]) << 4) | 32'(mund[s]);
    endfunction

    function automatic logic m_irq(int s);
        int half;
        half = cap_of(mch[s]) / 2;
        if (!men[s]) return 1'b0;
        return (s == 0) ? (mfr[s] <= half) : (mfr[s] >= half);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int s);
        @(posedge clk);
        @(negedge clk);
        wr[s] = 1'b0; rd[s] = 1'b0; strobe[s] = 1'b0;
    endtask

    task automatic cpu_wr(int s, logic [2:0] a, logic [31:0] wd);
        addr[s] = a; wdata[s] = wd; wr[s] = 1'b1;
        case (a)
            RA_CTRL: begin men[s] = wd[20]; if (wd[0]) m_clear(s); end
            RA_STAT: begin movr[s] = movr[s] & wd[4]; mund[s] = mund[s] & wd[0]; end
            RA_DATA:   if (s == 0) m_push(s, wd[23:0]);
            RA_DATA16: if (s == 0) m_push(s, {wd[15:0], 8'h00});
            default: ;
        endcase
        step(s);
    endtask

    task automatic cpu_rd(int s, logic [2:0] a, string req);
        logic [31:0] exp;
        logic [23:0] v;
        addr[s] = a; rd[s] = 1'b1;
        exp = '0;
        case (a)
            RA_CTRL: exp = 32'(men[s]) << 20;
            RA_STAT: exp = m_status(s);
            RA_DATA:   if (s == 1) begin v = m_pop(s); exp = {8'h00, v}; end
            RA_DATA16: if (s == 1) begin v = m_pop(s); exp = {16'h0, v[23:8]}; end
            default: exp = '0;
        endcase
        #1;
        chk(req, rdata[s], exp);
        step(s);
    endtask

    task automatic ser(int s, logic [23:0] sd, string req);
        logic [23:0] v;
        strobe[s] = 1'b1; din[s] = sd;
        #1;
        if (s == 0) begin
            v = m_pop(s);
            chk(req, {8'h0, dout[s]}, {8'h0, v});
        end else begin
            m_push(s, sd);
        end
        step(s);
    endtask

    task automatic verify(int s, string req);
        cpu_rd(s, RA_STAT, req);
        chk(req, {31'h0, irq[s]}, {31'h0, m_irq(s)});
    endtask

    task automatic set_ch(int s, int ch, bit en);
        chans[s] = 4'(ch);
        mch[s] = ch;
        cpu_wr(s, RA_CTRL, (32'(en) << 20) | 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int bias;
        int s;
        int k;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2; i++) begin
            chans[i] = 4'd1; addr[i] = '0; wr[i] = 0; rd[i] = 0; wdata[i] = '0;
            strobe[i] = 0; din[i] = '0; mch[i] = 1; movr[i] = 0; mund[i] = 0; men[i] = 0;
            m_clear(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        verify(0, "R12");
        verify(1, "R12");
        cpu_rd(0, RA_CTRL, "R12");
        cpu_rd(0, RA_CFG, "R1");

        // R1 capacity sweep on playback, fill past full then drain past empty
        foreach (n_list[j]) begin
            set_ch(0, n_list[j], 1'b1);
            n = cap_of(n_list[j]) * eff_ch(n_list[j]);
            for (int i = 0; i <= n; i++) begin
                cpu_wr(0, RA_DATA, $urandom);
                if (i % 16 == 0 || i >= n - 1) verify(0, "R1");
            end
            verify(0, "R5");
            for (int i = 0; i <= n; i++) begin
                ser(0, 24'h0, "R3");
                if (i % 16 == 0 || i >= n - 1) verify(0, "R11");
            end
            verify(0, "R6");
        end

        // R9 flag clearing by mask
        cpu_wr(0, RA_STAT, 32'h10);
        verify(0, "R9");
        cpu_wr(0, RA_STAT, 32'h0);
        verify(0, "R9");

        // R4 narrow window both directions
        set_ch(0, 2, 1'b0);
        cpu_wr(0, RA_DATA16, 32'hABCD_1234);
        ser(0, 24'h0, "R4");
        set_ch(1, 1, 1'b0);
        ser(1, 24'hA5B6C7, "R4");
        cpu_rd(1, RA_DATA16, "R4");
        ser(1, 24'h3C5A69, "R3");
        cpu_rd(1, RA_DATA, "R3");

        // R13 wrong-direction data accesses
        cpu_wr(0, RA_DATA, 32'h0011_2233);
        cpu_rd(0, RA_DATA, "R13");
        verify(0, "R13");
        cpu_wr(1, RA_DATA, 32'h0044_5566);
        verify(1, "R13");

        // R7 / R8 capture full and empty boundaries
        set_ch(1, 2, 1'b1);
        n = cap_of(2) * 2;
        for (int i = 0; i <= n; i++) begin
            ser(1, 24'($urandom), "R7");
            if (i % 16 == 0 || i >= n - 1) verify(1, "R7");
        end
        for (int i = 0; i <= n; i++) begin
            cpu_rd(1, RA_DATA, "R8");
            if (i % 16 == 0 || i >= n - 1) verify(1, "R8");
        end

        // R2 partial frame accounting with four channels
        set_ch(0, 4, 1'b0);
        for (int i = 0; i < 3; i++) cpu_wr(0, RA_DATA, 32'(i + 1));
        verify(0, "R2");
        cpu_wr(0, RA_DATA, 32'h4);
        verify(0, "R2");
        ser(0, 24'h0, "R2");
        verify(0, "R2");
        for (int i = 0; i < 3; i++) ser(0, 24'h0, "R2");
        verify(0, "R2");

        // R10 clear leaves flags alone
        ser(0, 24'h0, "R6");
        cpu_wr(0, RA_DATA, 32'h77);
        cpu_wr(0, RA_DATA, 32'h78);
        cpu_wr(0, RA_CTRL, 32'h1);
        verify(0, "R10");
        cpu_wr(0, RA_STAT, 32'h0);

        // random mix
        bias = 70;
        for (int it = 0; it < 4000; it++) begin
            if (it % 250 == 0) begin
                set_ch(0, $urandom_range(0, 10), 1'($urandom));
                set_ch(1, $urandom_range(0, 10), 1'($urandom));
                bias = 100 - bias;
            end
            s = $urandom_range(0, 1);
            k = $urandom_range(0, 99);
            if (k < 80) begin
                if (($urandom_range(0, 99) < bias) == (s == 0)) begin
                    if (s == 0) cpu_wr(0, $urandom_range(0, 1) ? RA_DATA : RA_DATA16, $urandom);
                    else        cpu_rd(1, $urandom_range(0, 1) ? RA_DATA : RA_DATA16, "R3");
                end else begin
                    ser(s, 24'($urandom), "R3");
                end
            end else if (k < 86) begin
                cpu_wr(s, RA_STAT, $urandom);
            end else if (k < 90) begin
                cpu_wr(s, RA_CTRL, $urandom & 32'h0010_0000);
            end else if (k < 92) begin
                cpu_wr(s, $urandom_range(0, 1) ? RA_DATA : RA_DATA16, $urandom);
            end else begin
                cpu_rd(s, RA_CTRL, "R11");
            end
            verify(s, "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    int n_list [4] = '{1, 3, 5, 8};

endmodule